// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sequences 16-bit reads from an external ROM for the CPU. The CPU offers a byte address with `reqValid` and says whether the address lies in the page-capable chip-select region. The block drives a word address, an active-low chip select and an active-low read strobe. It samples the data bus at the end of each access and returns the word with a one-clock `rspValid` pulse.

The first access of a burst always runs the full programmed wait count n. In the page-capable region with page mode enabled, further reads can continue the burst without releasing the strobes. Each such read must be the next sequential word in the same page, and it runs a short access of 1 to 4 cycles. The burst stops at a programmable page boundary, at any non-sequential address, or when no request is waiting. The next read then starts over with a full-length access.

The page-mode enable, in-page cycle field, page-size field and wait count are static inputs. The block samples them only when a burst starts. If n is set below the legal minimum, the block clamps it and flags the error.

Top module: `prom_page_reader`

## Requirements
- R1: Reads with `reqRegion`=0 are never page-mode reads. Each one is a separate full-length access, whatever `cfgPageEn` holds.
- R2: With `cfgPageEn`=0, every read is a full-length access. `memCsN`/`memRdN` go high for at least one cycle between reads.
- R3: An in-page (continuation) access lasts `cfgPageCyc`+1 cycles: 2'b00→1, 2'b01→2, 2'b10→3, 2'b11→4.
- R4: The first access of a burst keeps the strobes low for n=`cfgWaitN` cycles, starting in the cycle after acceptance. The block samples `memData` at the clock edge that ends the access.
- R5: `cfgPageSize` sets the page length: 2'b00→64, 2'b01→32, 2'b10→16, 2'b11→8 bytes. A sequential read that crosses into the next page starts a new full-length access.
- R6: A read continues a burst only if all of these hold: the burst is a page burst, `reqRegion`=1, the address is the previous address plus 2, and it is in the same page. `reqReady` is high in idle. During the last cycle of an access, `reqReady` is high only for a read that may continue the burst. Any other read waits, the strobes go high for one cycle, and the read then starts a full-length access.
- R7: In page mode, an n below `cfgPageCyc`+2 is clamped to `cfgPageCyc`+2. This also sets `cfgErr`, which stays set until reset. For a normal read, n=0 is treated as 1 and does not set `cfgErr`.
- R8: `memCsN` and `memRdN` are low together exactly while an access is in progress, and high when idle.
- R9: All configuration inputs are sampled when a burst starts. Changes made during a burst have no effect until the next burst.
- R10: `rspValid` is high for exactly one clock per returned word, in the cycle after the sampling edge. `rspData` holds the word until the next one arrives.
- R11: `memAddr` carries `reqAddr`[23:1] of the current read and stays constant through each access.
- R12: After reset: `memCsN`=`memRdN`=1, `rspValid`=0, `rspData`=0, `memAddr`=0, `cfgErr`=0 and `reqReady`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Read request offered |
| reqAddr | input | 24 | Byte address of the read (even) |
| reqRegion | input | 1 | 1 when the address lies in the page-capable region |
| reqReady | output | 1 | Request is accepted at this clock edge when high |
| rspValid | output | 1 | One-clock pulse per returned word |
| rspData | output | 16 | Returned word, held until the next |
| cfgPageEn | input | 1 | Page mode enable |
| cfgPageCyc | input | 2 | In-page access length code |
| cfgPageSize | input | 2 | Page length code |
| cfgWaitN | input | 4 | Full access length n in cycles |
| cfgErr | output | 1 | Sticky flag: n was below the page-mode minimum |
| memAddr | output | 23 | Word address to the ROM |
| memCsN | output | 1 | Chip select, active low |
| memRdN | output | 1 | Read strobe, active low |
| memData | input | 16 | ROM data bus |

## Verification
A wrong beat counter or a wrong latched length shows up at once. The strobes rise one cycle early or late, and the `rspValid` pulse moves with them in the very next cycle. A bad sequential or page-boundary decision shows as a continued burst where the strobes should have gone high, or the reverse. Because `reqReady` is combinational on the request, a bad decision is also visible in the last cycle of the access. A stale address register or capture enable shows as a wrong `memAddr` during the access, or as wrong `rspData` in the cycle after sampling. The bench compares every output on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } promState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadAddr;   // take reqAddr into the address register
    logic capture;    // sample memData and pulse rspValid
  } dpCtrl_t;

endpackage

// File: rtl/prom_ctrl.sv
module prom_ctrl
  import prom_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRegion,
  input  logic              cfgPageEn,
  input  logic [1:0]        cfgPageCyc,
  input  logic [1:0]        cfgPageSize,
  input  logic [WAIT_W-1:0] cfgWaitN,
  input  logic [ADDR_W-1:0] curAddr,
  output dpCtrl_t           dpCtrl,
  output logic              busy,
  output logic              reqReady,
  output logic              cfgErr
);

  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

  promState_t        state;
  logic [WAIT_W-1:0] beatCnt;
  logic [WAIT_W-1:0] beatLen;
  logic [WAIT_W-1:0] burstShort;
  logic [1:0]        burstSize;
  logic              burstPage;

  logic              lastCycle;
  logic              nextSeq;
  logic              samePage;
  logic              canCont;
  logic              startNew;
  logic              contBeat;
  logic [2:0]        pageShift;
  logic [ADDR_W-1:0] pageMask;

  logic              startPage;
  logic [WAIT_W-1:0] shortNew;
  logic [WAIT_W-1:0] minNew;
  logic              tooShort;
  logic [WAIT_W-1:0] clampN;

  // page geometry of the running burst
  always_comb begin
    unique case (burstSize)
      2'b00:   pageShift = 3'd6;
      2'b01:   pageShift = 3'd5;
      2'b10:   pageShift = 3'd4;
      default: pageShift = 3'd3;
    endcase
    pageMask = {ADDR_W{1'b1}} << pageShift;
  end

  assign lastCycle = (state == ST_READ) && (beatCnt == beatLen);
  assign nextSeq   = (reqAddr == curAddr + WORD_STEP);
  assign samePage  = ((reqAddr ^ curAddr) & pageMask) == '0;
  assign canCont   = burstPage && reqRegion && nextSeq && samePage;
  assign reqReady  = (state == ST_IDLE) || (lastCycle && canCont);
  assign startNew  = (state == ST_IDLE) && reqValid;
  assign contBeat  = lastCycle && reqValid && canCont;
  assign busy      = (state == ST_READ);

  assign dpCtrl.loadAddr = reqValid && reqReady;
  assign dpCtrl.capture  = lastCycle;

  // configuration sampled for a new burst
  assign startPage = cfgPageEn && reqRegion;
  assign shortNew  = WAIT_W'(cfgPageCyc) + ONE;
  assign minNew    = startPage ? (shortNew + ONE) : ONE;
  assign tooShort  = cfgWaitN < minNew;
  assign clampN    = tooShort ? minNew : cfgWaitN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatCnt    <= '0;
      beatLen    <= '0;
      burstShort <= ONE;
      burstSize  <= 2'b10;
      burstPage  <= 1'b0;
      cfgErr     <= 1'b0;
    end else if (startNew) begin
      state      <= ST_READ;
      beatCnt    <= ONE;
      beatLen    <= clampN;
      burstShort <= shortNew;
      burstSize  <= cfgPageSize;
      burstPage  <= startPage;
      if (startPage && tooShort) cfgErr <= 1'b1;
    end else if (lastCycle) begin
      if (contBeat) begin
        beatCnt <= ONE;
        beatLen <= burstShort;
      end else begin
        state <= ST_IDLE;
      end
    end else if (state == ST_READ) begin
      beatCnt <= beatCnt + ONE;
    end
  end

  // counter never leaves the window of the current access
  p_cnt_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) |-> (beatCnt >= ONE && beatCnt <= beatLen));

  // a page burst never starts with a first access shorter than short+1
  p_clamp_min_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startNew && startPage) |=> (beatLen > burstShort));

  // error flag never clears once set
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  // latched page geometry cannot move while a burst runs
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) |=> ($stable(burstSize) && $stable(burstShort) && $stable(burstPage)));

  // a continued beat lands on the next word of the datapath address
  p_cont_seq_r6: assert property (@(posedge clk) disable iff (!rstN)
    contBeat |=> (curAddr == $past(curAddr) + WORD_STEP));

endmodule

// File: rtl/prom_datapath.sv
module prom_datapath
  import prom_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (dpCtrl.loadAddr) curAddr <= reqAddr;
      if (dpCtrl.capture)  rspData <= memData;
      rspValid <= dpCtrl.capture;
    end
  end

  // returned word held between captures
  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.capture |=> $stable(rspData));

  // address register only moves on a load strobe
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.loadAddr |=> $stable(curAddr));

  // response pulse follows a capture by exactly one clock
  p_valid_after_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.capture |=> rspValid);

endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
  import prom_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRegion,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  input  logic              cfgPageEn,
  input  logic [1:0]        cfgPageCyc,
  input  logic [1:0]        cfgPageSize,
  input  logic [WAIT_W-1:0] cfgWaitN,
  output logic              cfgErr,
  output logic [ADDR_W-2:0] memAddr,
  output logic              memCsN,
  output logic              memRdN,
  input  logic [DATA_W-1:0] memData
);

  dpCtrl_t           dpCtrl;
  logic              busy;
  logic [ADDR_W-1:0] curAddr;

  prom_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqAddr     (reqAddr),
    .reqRegion   (reqRegion),
    .cfgPageEn   (cfgPageEn),
    .cfgPageCyc  (cfgPageCyc),
    .cfgPageSize (cfgPageSize),
    .cfgWaitN    (cfgWaitN),
    .curAddr     (curAddr),
    .dpCtrl      (dpCtrl),
    .busy        (busy),
    .reqReady    (reqReady),
    .cfgErr      (cfgErr)
  );

  prom_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .reqAddr  (reqAddr),
    .memData  (memData),
    .curAddr  (curAddr),
    .rspData  (rspData),
    .rspValid (rspValid)
  );

  assign memAddr = curAddr[ADDR_W-1:1];
  assign memCsN  = ~busy;
  assign memRdN  = ~busy;

  // strobes stay low while an access continues into its next cycle
  p_strobe_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && !rspValid && $past(!memCsN)) |-> !memRdN);

  // an idle bus always offers to take a request
  p_idle_ready_r12: assert property (@(posedge clk) disable iff (!rstN)
    memCsN |-> reqReady);

endmodule

// File: tb/sim_prom_page_reader.sv
module sim_prom_page_reader;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int WAIT_W = 4;
  localparam int WATCHDOG = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqRegion = 1'b0;
  logic              reqReady;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic              cfgPageEn = 1'b0;
  logic [1:0]        cfgPageCyc = 2'b00;
  logic [1:0]        cfgPageSize = 2'b10;
  logic [WAIT_W-1:0] cfgWaitN = 4'd3;
  logic              cfgErr;
  logic [ADDR_W-2:0] memAddr;
  logic              memCsN;
  logic              memRdN;
  logic [DATA_W-1:0] memData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit cmpOn = 1'b0;
  string phase = "R12";

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] romWord(input logic [ADDR_W-2:0] w);
    return w[15:0] ^ {w[7:0], w[15:8]} ^ 16'h3C5A;
  endfunction

  assign memData = romWord(memAddr);

  prom_page_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqRegion(reqRegion), .reqReady(reqReady), .rspValid(rspValid),
    .rspData(rspData), .cfgPageEn(cfgPageEn), .cfgPageCyc(cfgPageCyc),
    .cfgPageSize(cfgPageSize), .cfgWaitN(cfgWaitN), .cfgErr(cfgErr),
    .memAddr(memAddr), .memCsN(memCsN), .memRdN(memRdN), .memData(memData)
  );

  // behavioural reference state
  bit              mBusy, mPm, mRspV, mErr;
  int              mCnt, mLen, mShort, mPageBytes;
  int              mAddr;
  logic [DATA_W-1:0] mRspD;

  function automatic bit mayContinue(input int a, input bit region);
    return mPm && region && (a == mAddr + 2) && ((a / mPageBytes) == (mAddr / mPageBytes));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mPm = 0; mRspV = 0; mErr = 0;
      mCnt = 0; mLen = 0; mShort = 1; mPageBytes = 16; mAddr = 0; mRspD = '0;
    end else begin
      mRspV = 0;
      if (!mBusy) begin
        if (reqValid) begin
          int minN;
          int n;
          mPm = cfgPageEn && reqRegion;
          mShort = int'(cfgPageCyc) + 1;
          minN = mPm ? mShort + 1 : 1;
          n = int'(cfgWaitN);
          if (n < minN) begin
            n = minN;
            if (mPm) mErr = 1;
          end
          mLen = n; mCnt = 1; mBusy = 1;
          mAddr = int'(reqAddr);
          mPageBytes = 64 >> cfgPageSize;
        end
      end else if (mCnt == mLen) begin
        mRspV = 1;
        mRspD = romWord(ADDR_W'(mAddr) >> 1);
        if (reqValid && mayContinue(int'(reqAddr), reqRegion)) begin
          mAddr = int'(reqAddr); mLen = mShort; mCnt = 1;
        end else begin
          mBusy = 0;
        end
      end else begin
        mCnt++;
      end
    end
  end

  task automatic chk(input string sig, input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s (phase %s) at cycle %0d: actual=%0h expected=%0h",
               rq, sig, phase, cycles, act, exp);
    end
  endtask

  // compare every output once per clock, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (cmpOn) begin
      bit expReady;
      expReady = !mBusy || ((mCnt == mLen) && mayContinue(int'(reqAddr), reqRegion));
      chk("memCsN",   "R8",  int'(memCsN),   int'(!mBusy));
      chk("memRdN",   "R8",  int'(memRdN),   int'(!mBusy));
      chk("memAddr",  "R11", int'(memAddr),  mAddr >> 1);
      chk("rspValid", "R10", int'(rspValid), int'(mRspV));
      chk("rspData",  "R10", int'(rspData),  int'(mRspD));
      chk("reqReady", "R6",  int'(reqReady), int'(expReady));
      chk("cfgErr",   "R7",  int'(cfgErr),   int'(mErr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL R8 watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // offer one read and return in the cycle after it is taken
  task automatic rd(input int a, input bit region);
    reqValid = 1'b1;
    reqAddr = ADDR_W'(a);
    reqRegion = region;
    #1;
    while (!reqReady) begin
      @(negedge clk); #3;
    end
    @(negedge clk); #2;
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    repeat (n) begin @(negedge clk); end
    #2;
  endtask

  task automatic setCfg(input bit en, input int cyc, input int size, input int n);
    cfgPageEn = en;
    cfgPageCyc = 2'(cyc);
    cfgPageSize = 2'(size);
    cfgWaitN = WAIT_W'(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rstN = 1'b1;
    @(negedge clk); #2;
    // R12: reset state
    chk("memCsN",   "R12", int'(memCsN),   1);
    chk("memRdN",   "R12", int'(memRdN),   1);
    chk("rspValid", "R12", int'(rspValid), 0);
    chk("rspData",  "R12", int'(rspData),  0);
    chk("memAddr",  "R12", int'(memAddr),  0);
    chk("cfgErr",   "R12", int'(cfgErr),   0);
    chk("reqReady", "R12", int'(reqReady), 1);
    cmpOn = 1'b1;

    // R2: page mode off, sequential reads are all full-length
    phase = "R2";
    setCfg(0, 0, 2, 3);
    for (int i = 0; i < 4; i++) rd(32'h100 + 2*i, 1);
    idle(6);

    // R4: long first access, then short page beats
    phase = "R4";
    setCfg(1, 1, 2, 9);
    for (int i = 0; i < 5; i++) rd(32'h180 + 2*i, 1);
    idle(4);

    // R3: each page-cycle code at its legal minimum n
    phase = "R3";
    for (int pc = 0; pc < 4; pc++) begin
      setCfg(1, pc, 2, pc + 2);
      for (int i = 0; i < 10; i++) rd(32'h200 + 64*pc + 2*i, 1);
      idle(3);
    end

    // R5: each page size, starting mid-page and crossing boundaries
    phase = "R5";
    for (int sz = 0; sz < 4; sz++) begin
      setCfg(1, 1, sz, 4);
      for (int i = 0; i < 40; i++) rd(32'h1008 + 2*i, 1);
      idle(3);
    end

    // R6: jumps, backward steps and a region change end the burst
    phase = "R6";
    setCfg(1, 1, 2, 4);
    rd(32'h300, 1); rd(32'h302, 1); rd(32'h308, 1); rd(32'h30a, 1);
    rd(32'h306, 1); rd(32'h308, 1); rd(32'h30a, 0); rd(32'h30c, 1);
    rd(32'h30c, 1); rd(32'h30e, 1);
    idle(4);

    // R1: other region never bursts, n=0 becomes 1 with no error
    phase = "R1";
    setCfg(1, 0, 3, 0);
    for (int i = 0; i < 6; i++) rd(32'h400 + 2*i, 0);
    idle(3);
    setCfg(1, 2, 3, 5);
    for (int i = 0; i < 4; i++) rd(32'h480 + 2*i, 0);
    idle(3);

    // R9: configuration changes mid-burst wait for the next burst
    phase = "R9";
    setCfg(1, 0, 3, 2);
    rd(32'h600, 1);
    setCfg(0, 3, 0, 9);
    rd(32'h602, 1); rd(32'h604, 1); rd(32'h606, 1);
    rd(32'h608, 1); rd(32'h60a, 1);
    idle(4);
    setCfg(1, 3, 0, 9);
    rd(32'h700, 1); setCfg(1, 0, 3, 15); rd(32'h702, 1); rd(32'h704, 1);
    idle(4);

    // R7: n below the page-mode minimum is clamped and flagged
    phase = "R7";
    setCfg(1, 3, 2, 1);
    for (int i = 0; i < 5; i++) rd(32'h800 + 2*i, 1);
    idle(4);
    setCfg(1, 0, 2, 3);
    rd(32'h900, 1); rd(32'h902, 1);
    idle(5);

    cmpOn = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule